// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves the branch class of a small 8-bit processor. Each cycle it may be offered one fetched opcode byte, the signed displacement byte that follows it, the address of the opcode and the current sign, carry and zero flags. The branch class is the high opcode nibble 0xB. For a branch-class opcode the low nibble selects one of six flag tests, written as hex letters A to F. One clock later the block reports whether the branch is taken, the resolved target and the next instruction address. Opcodes outside the class do not affect it.

The target is the address after the two-byte instruction plus the sign-extended displacement, wrapped to the address width. Two displacements give useful idioms. A displacement of 0xFF lands on the displacement byte itself, which is then fetched as a return opcode, so the branch acts as a conditional return. A displacement of 0xFE lands on the branch opcode again, so the instruction repeats while its condition holds. The block flags both cases on their own outputs, so a sequencer can act on them without comparing addresses. Low nibbles 0 to 9 are reserved and are reported as illegal.

Top module: `cond_branch_unit`

## Requirements
- R1: When `issue_i` is high and `opcode_i[7:4]` equals 0xB, `done_o` is high in the next cycle. In any other case `done_o`, `taken_o`, `illegal_o`, `ret_land_o` and `spin_o` are low in the next cycle.
- R2: Low nibble 0xA is taken when the sign flag is 1. Low nibble 0xB is taken when the sign flag is 0.
- R3: Low nibble 0xC is taken when the carry flag is 1. Low nibble 0xD is taken when the carry flag is 0.
- R4: Low nibble 0xE is taken when the zero flag is 1. Low nibble 0xF is taken when the zero flag is 0.
- R5: For a legal branch, `target_o` equals `pc_i + 2 + sign_extend(disp_i)`, taken modulo 2^AW.
- R6: For a legal branch, `next_pc_o` equals `target_o` when the branch is taken and `pc_i + 2` (mod 2^AW) when it is not.
- R7: Low nibbles 0x0 to 0x9 set `illegal_o`, clear `taken_o` and give `next_pc_o = pc_i`.
- R8: A taken legal branch with `disp_i = 0xFF` gives `next_pc_o = pc_i + 1` and sets `ret_land_o`. `ret_land_o` is low in all other cases.
- R9: A taken legal branch with `disp_i = 0xFE` gives `next_pc_o = pc_i` and sets `spin_o`. `spin_o` is low in all other cases.
- R10: While `rst` is high, every output is zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Opcode, displacement and address are valid this cycle |
| opcode_i | input | 8 | Fetched opcode byte |
| disp_i | input | 8 | Signed displacement byte |
| pc_i | input | AW | Address of the opcode byte |
| flag_sign_i | input | 1 | Sign flag |
| flag_carry_i | input | 1 | Carry flag |
| flag_zero_i | input | 1 | Zero flag |
| done_o | output | 1 | A branch-class opcode was resolved |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Reserved branch nibble |
| ret_land_o | output | 1 | Taken branch lands on its own displacement byte |
| spin_o | output | 1 | Taken branch lands on its own opcode |
| target_o | output | AW | Resolved branch target |
| next_pc_o | output | AW | Next instruction address |

## Verification
The assertions assume that the inputs are stable around each rising edge and that `issue_i` is low during reset. With that assumption, one sample of the opcode, flags, displacement and address fixes the outputs of the next cycle. The bench changes inputs only on falling edges and holds `issue_i` low while `rst` is high. It sweeps every low nibble against all eight flag combinations at the boundary displacements and at addresses near both ends of the address space. It then sweeps every displacement, and then every non-branch opcode, so that the wrap and sign-extension cases are reached.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef struct packed {
    logic sign;
    logic carry;
    logic zero;
  } cbu_flags_t;

  localparam logic [3:0] CBU_CLASS      = 4'hB;
  localparam logic [3:0] CBU_FIRST_COND = 4'hA;

  // selector -> flag test; reserved selectors never fire
  function automatic logic cbu_test(input logic [3:0] sel, input cbu_flags_t f);
    logic r;
    case (sel)
      4'hA:    r = f.sign;
      4'hB:    r = ~f.sign;
      4'hC:    r = f.carry;
      4'hD:    r = ~f.carry;
      4'hE:    r = f.zero;
      4'hF:    r = ~f.zero;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  input  cbu_flags_t       flags_i,
  output logic             legal_o,
  output logic             hit_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0] hit_vec;

  // one flag test per selector value, picked by a mux
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign hit_vec[g] = cbu_test(4'(g), flags_i);
  end

  assign legal_o = (4'(sel_i) >= CBU_FIRST_COND);
  assign hit_o   = hit_vec[sel_i];
endmodule

// File: rtl/cbu_target_calc.sv
module cbu_target_calc #(
  parameter int AW     = 16,
  parameter int DISP_W = 8,
  parameter int ILEN   = 2
) (
  input  logic [AW-1:0]     pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [AW-1:0]     fall_o,
  output logic [AW-1:0]     target_o,
  output logic              ret_land_o,
  output logic              spin_o
);
  localparam int EXT_W = AW - DISP_W;
  localparam logic [DISP_W-1:0] DISP_RET  = {DISP_W{1'b1}};
  localparam logic [DISP_W-1:0] DISP_SPIN = {{(DISP_W-1){1'b1}}, 1'b0};

  logic [AW-1:0] disp_ext;

  assign disp_ext   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign fall_o     = pc_i + AW'(ILEN);
  assign target_o   = fall_o + disp_ext;
  assign ret_land_o = (disp_i == DISP_RET);
  assign spin_o     = (disp_i == DISP_SPIN);
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic [7:0]    opcode_i,
  input  logic [7:0]    disp_i,
  input  logic [AW-1:0] pc_i,
  input  logic          flag_sign_i,
  input  logic          flag_carry_i,
  input  logic          flag_zero_i,
  output logic          done_o,
  output logic          taken_o,
  output logic          illegal_o,
  output logic          ret_land_o,
  output logic          spin_o,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] next_pc_o
);
  localparam int DISP_W = 8;
  localparam int ILEN   = 2;

  cbu_flags_t    flags;
  logic          is_br, legal, hit, take;
  logic [AW-1:0] fall, tgt;
  logic          ret_pat, spin_pat;

  assign flags = '{sign: flag_sign_i, carry: flag_carry_i, zero: flag_zero_i};
  assign is_br = issue_i && (opcode_i[7:4] == CBU_CLASS);
  assign take  = is_br && legal && hit;

  cbu_cond_eval #(.SEL_W(4)) u_cond (
    .sel_i   (opcode_i[3:0]),
    .flags_i (flags),
    .legal_o (legal),
    .hit_o   (hit)
  );

  cbu_target_calc #(.AW(AW), .DISP_W(DISP_W), .ILEN(ILEN)) u_tgt (
    .pc_i       (pc_i),
    .disp_i     (disp_i),
    .fall_o     (fall),
    .target_o   (tgt),
    .ret_land_o (ret_pat),
    .spin_o     (spin_pat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      taken_o    <= 1'b0;
      illegal_o  <= 1'b0;
      ret_land_o <= 1'b0;
      spin_o     <= 1'b0;
      target_o   <= '0;
      next_pc_o  <= '0;
    end else begin
      done_o     <= is_br;
      taken_o    <= take;
      illegal_o  <= is_br && !legal;
      ret_land_o <= take && ret_pat;
      spin_o     <= take && spin_pat;
      if (is_br) begin
        target_o  <= legal ? tgt : pc_i;
        next_pc_o <= !legal ? pc_i : (hit ? tgt : fall);
      end
    end
  end
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_i,
  input logic [7:0]    opcode_i,
  input logic [7:0]    disp_i,
  input logic [AW-1:0] pc_i,
  input logic          flag_sign_i,
  input logic          flag_carry_i,
  input logic          flag_zero_i,
  input logic          done_o,
  input logic          taken_o,
  input logic          illegal_o,
  input logic          ret_land_o,
  input logic          spin_o,
  input logic [AW-1:0] target_o,
  input logic [AW-1:0] next_pc_o
);
  logic br, lg;
  assign br = issue_i && (opcode_i[7:4] == 4'hB);
  assign lg = br && (opcode_i[3:0] >= 4'hA);

  p_done_r1: assert property (@(posedge clk) disable iff (rst) br |=> done_o);
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !br |=> !(done_o || taken_o || illegal_o || ret_land_o || spin_o));
  p_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (br && opcode_i[3:0] == 4'hA && flag_sign_i) |=> taken_o);
  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (br && opcode_i[3:0] == 4'hD && flag_carry_i) |=> !taken_o);
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (br && opcode_i[3:0] == 4'hE && flag_zero_i) |=> taken_o);
  p_taken_r6: assert property (@(posedge clk) disable iff (rst)
    lg |=> (!taken_o || next_pc_o == target_o));
  p_fall_r6: assert property (@(posedge clk) disable iff (rst)
    lg |=> (taken_o || next_pc_o == AW'($past(pc_i) + AW'(2))));
  p_illegal_r7: assert property (@(posedge clk) disable iff (rst)
    (br && !lg) |=> (illegal_o && !taken_o && next_pc_o == $past(pc_i)));
  p_ret_r8: assert property (@(posedge clk) disable iff (rst)
    (lg && disp_i == 8'hFF) |=> (!taken_o || (ret_land_o && next_pc_o == AW'($past(pc_i) + AW'(1)))));
  p_spin_r9: assert property (@(posedge clk) disable iff (rst)
    (lg && disp_i == 8'hFE) |=> (!taken_o || (spin_o && next_pc_o == $past(pc_i))));
  p_reset_r10: assert property (@(posedge clk)
    rst |=> !(done_o || taken_o || illegal_o || ret_land_o || spin_o));
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .issue_i(issue_i), .opcode_i(opcode_i), .disp_i(disp_i),
  .pc_i(pc_i), .flag_sign_i(flag_sign_i), .flag_carry_i(flag_carry_i),
  .flag_zero_i(flag_zero_i), .done_o(done_o), .taken_o(taken_o),
  .illegal_o(illegal_o), .ret_land_o(ret_land_o), .spin_o(spin_o),
  .target_o(target_o), .next_pc_o(next_pc_o)
);

// File: tb/cond_branch_unit_tb.sv
`timescale 1ns/1ps
module cond_branch_unit_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issue_i = 1'b0;
  logic [7:0]    opcode_i = '0;
  logic [7:0]    disp_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic          flag_sign_i = 1'b0, flag_carry_i = 1'b0, flag_zero_i = 1'b0;
  logic          done_o, taken_o, illegal_o, ret_land_o, spin_o;
  logic [AW-1:0] target_o, next_pc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cond_branch_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .opcode_i(opcode_i), .disp_i(disp_i),
    .pc_i(pc_i), .flag_sign_i(flag_sign_i), .flag_carry_i(flag_carry_i),
    .flag_zero_i(flag_zero_i), .done_o(done_o), .taken_o(taken_o),
    .illegal_o(illegal_o), .ret_land_o(ret_land_o), .spin_o(spin_o),
    .target_o(target_o), .next_pc_o(next_pc_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_take(input logic [3:0] n, input bit s, input bit c, input bit z);
    if (n == 4'hA) return s;          // R2
    if (n == 4'hB) return !s;         // R2
    if (n == 4'hC) return c;          // R3
    if (n == 4'hD) return !c;         // R3
    if (n == 4'hE) return z;          // R4
    if (n == 4'hF) return !z;         // R4
    return 0;
  endfunction

  // drive on a falling edge, sample on the next falling edge
  task automatic run_branch(input logic [3:0] n, input logic [7:0] d, input int pc,
                            input bit s, input bit c, input bit z);
    int tgt, exp_next;
    bit t, lg;
    @(negedge clk);
    issue_i = 1; opcode_i = {4'hB, n}; disp_i = d; pc_i = AW'(pc);
    flag_sign_i = s; flag_carry_i = c; flag_zero_i = z;
    @(negedge clk);
    issue_i = 0;
    lg  = (n >= 4'hA);
    t   = lg && exp_take(n, s, c, z);
    tgt = (pc + 2 + int'($signed(d))) & ((1 << AW) - 1);
    chk("R1 done", done_o, 1);
    if (!lg) begin
      chk("R7 illegal", illegal_o, 1);
      chk("R7 taken", taken_o, 0);
      chk("R7 next_pc", next_pc_o, pc);
      chk("R8 ret_land", ret_land_o, 0);
      chk("R9 spin", spin_o, 0);
    end else begin
      exp_next = t ? tgt : ((pc + 2) & ((1 << AW) - 1));
      chk("R7 illegal", illegal_o, 0);
      if (n < 4'hC) chk("R2 taken", taken_o, t);
      else if (n < 4'hE) chk("R3 taken", taken_o, t);
      else chk("R4 taken", taken_o, t);
      chk("R5 target", target_o, tgt);
      chk("R6 next_pc", next_pc_o, exp_next);
      chk("R8 ret_land", ret_land_o, t && d == 8'hFF);
      chk("R9 spin", spin_o, t && d == 8'hFE);
      if (t && d == 8'hFF) chk("R8 next_pc", next_pc_o, (pc + 1) & ((1 << AW) - 1));
      if (t && d == 8'hFE) chk("R9 next_pc", next_pc_o, pc);
    end
  endtask

  initial begin
    int pcs[4] = '{0, 1, 'h7FFF, 'hFFFF};
    logic [7:0] ds[8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h02, 8'hFD};
    repeat (3) @(negedge clk);
    chk("R10 done", done_o, 0);
    chk("R10 taken", taken_o, 0);
    chk("R10 next_pc", next_pc_o, 0);
    chk("R10 target", target_o, 0);
    rst = 0;
    foreach (pcs[i])
      foreach (ds[j])
        for (int n = 0; n < 16; n++)
          for (int f = 0; f < 8; f++)
            run_branch(4'(n), ds[j], pcs[i], f[2], f[1], f[0]);
    foreach (pcs[i])
      for (int d = 0; d < 256; d++)
        run_branch(4'hE, 8'(d), pcs[i], 0, 0, 1);
    // non-branch opcodes, and branch bytes without issue
    for (int op = 0; op < 256; op++) begin
      @(negedge clk);
      issue_i = (op[7:4] != 4'hB); opcode_i = 8'(op); disp_i = 8'hFE; pc_i = 16'h4000;
      flag_sign_i = 1; flag_carry_i = 1; flag_zero_i = 1;
      @(negedge clk);
      issue_i = 0;
      chk("R1 done low", done_o, 0);
      chk("R1 taken low", taken_o, 0);
      chk("R1 illegal low", illegal_o, 0);
      chk("R1 spin low", spin_o, 0);
    end
    // reset mid-run clears outputs
    run_branch(4'hE, 8'hFE, 16'h1000, 0, 0, 1);
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R10 done", done_o, 0);
    chk("R10 spin", spin_o, 0);
    chk("R10 next_pc", next_pc_o, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule